// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block turns a 32-bit binary floating-point value into a 16-bit one and places the narrowed value into one half of a 32-bit destination word. The other half of that word is passed through from the old destination word unchanged. The block sits in a floating-point datapath next to the register file. Each cycle it takes an operand, the old destination word and a half select, and one clock later it returns the merged word.

The narrowing honours a 2-bit rounding mode and rebiases the exponent. Results too small for a normal 16-bit value are produced as correctly rounded subnormals. Overflow follows the rounding direction. Special values follow three controls: an alternative 16-bit format that has no infinities or NaNs and saturates instead, a default-NaN substitute, and an underflow-exception enable. Four per-operation exception flags come out alongside the word. Each flag is meant to be OR-ed into a sticky status register elsewhere.

The block keeps no state beyond its output register. Flushing of input subnormals to zero and exception trapping are handled outside it.

Top module: `fp_narrow`

## Requirements
- R1: A finite input whose rebiased exponent (input exponent minus 112) is in 1..30 and whose dropped low 13 mantissa bits are zero yields sign, rebiased exponent and the top 10 mantissa bits, with no flags raised.
- R2: With `sel_upper_i`=1 the narrowed value goes to bits 31:16 and bits 15:0 come from `dest_i`. With `sel_upper_i`=0 it goes to bits 15:0 and bits 31:16 come from `dest_i`.
- R3: Rounding mode encoding: 0 is nearest-even (increment when guard=1 and (sticky=1 or LSB=1)), 1 is toward +infinity, 2 is toward -infinity, 3 is toward zero. Modes 1 and 2 increment the magnitude on any nonzero dropped bit when the sign points their way. Any nonzero dropped bit raises inexact.
- R4: A rounding carry out of the 10-bit mantissa clears it and increments the exponent. This covers a subnormal rounding up to 0x0400 and a value of 30 rounding into overflow.
- R5: In the standard format, a final exponent of 31 or more raises overflow and inexact. The result is infinity (exponent 0x1F, mantissa 0) for mode 0, for mode 1 with a positive value and for mode 2 with a negative value. Otherwise it is the largest finite value (0x1E/0x3FF).
- R6: In the alternative format, exponent 31 is an ordinary finite value. A final exponent of 32 or more saturates to 0x1F/0x3FF with the input sign, raises invalid and never raises inexact or overflow.
- R7: An infinite input gives signed infinity (0x1F/0) with no flags in the standard format, and 0x1F/0x3FF with invalid in the alternative format.
- R8: A NaN input with input mantissa bit 22 = 0 is signalling and raises invalid. In the standard format without default-NaN, the result keeps the sign and the top 10 payload bits, with bit 9 forced to 1. With default-NaN the result is 0x7E00. The alternative format overrides default-NaN: it gives a signed zero and raises invalid.
- R9: Values below the smallest normal, including input subnormals, are shifted into a 16-bit subnormal with guard and sticky kept, and are rounded per R3 in all four modes.
- R10: Underflow is raised when the value was below the normal range before rounding and either the result is inexact or `uf_en_i`=1.
- R11: A zero input gives a zero of the same sign with no flags raised, whatever the mode.
- R12: Outputs are registered. The result for inputs present at a rising edge appears after that edge. Reset is synchronous and active-high, and clears the word and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 32 | Single-precision operand |
| dest_i | input | 32 | Old destination word |
| sel_upper_i | input | 1 | 1 writes bits 31:16, 0 writes bits 15:0 |
| rmode_i | input | 2 | Rounding mode (0 nearest, 1 up, 2 down, 3 zero) |
| alt_fmt_i | input | 1 | Alternative 16-bit format with no infinities or NaNs |
| dflt_nan_i | input | 1 | Substitute the default NaN |
| uf_en_i | input | 1 | Underflow exception enable |
| word_o | output | 32 | Merged destination word |
| flag_invalid_o | output | 1 | Invalid operation |
| flag_overflow_o | output | 1 | Overflow |
| flag_underflow_o | output | 1 | Underflow |
| flag_inexact_o | output | 1 | Inexact |

## Verification
The bench builds the converter with its default widths: an 8-bit exponent and 23-bit mantissa narrowed to a 5-bit exponent and 10-bit mantissa. At these widths every boundary can be reached with short hand-computed constants. These include the rebias edge at input exponent 112/113, the largest finite value and the rounding carry into overflow at exponent 142, and the alternative-format saturation at 144. Guard and sticky positions at bits 12 and below, subnormal shifts up to the clamp, and input subnormals are all hit exactly. The vectors alternate the half select so that both merge directions are checked against the untouched half.

// File: rtl/fp_narrow_pkg.sv
package fp_narrow_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_UP      = 2'd1,
    RM_DOWN    = 2'd2,
    RM_ZERO    = 2'd3
  } rmode_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } flags_t;

endpackage

// File: rtl/fp_narrow_align.sv
// Rebias the exponent and line up the significand for the narrow format,
// producing the kept mantissa bits plus guard and sticky.
module fp_narrow_align #(
  parameter int SRC_EXP_W = 8,
  parameter int SRC_MAN_W = 23,
  parameter int DST_EXP_W = 5,
  parameter int DST_MAN_W = 10
) (
  input  logic [SRC_EXP_W-1:0] exp_i,
  input  logic [SRC_MAN_W-1:0] man_i,
  output logic [DST_MAN_W-1:0] kept_o,
  output logic                 guard_o,
  output logic                 sticky_o,
  output logic                 tiny_o,
  output logic [SRC_EXP_W:0]   exp_o
);
  localparam int SIG_W   = SRC_MAN_W + 1;
  localparam int EXT_W   = 2 * SIG_W;
  localparam int BDIFF_I = (2**(SRC_EXP_W-1) - 1) - (2**(DST_EXP_W-1) - 1);
  localparam int SHMAX_I = DST_MAN_W + 2;
  localparam int GRD_POS = EXT_W - 2 - DST_MAN_W;
  localparam logic [SRC_EXP_W:0] BDIFF  = BDIFF_I[SRC_EXP_W:0];
  localparam logic [SRC_EXP_W:0] SH_MAX = SHMAX_I[SRC_EXP_W:0];

  logic [SRC_EXP_W-1:0] e_eff;
  logic                 hidden;
  logic [SRC_EXP_W:0]   sh_full;
  logic [SRC_EXP_W:0]   sh;
  logic [EXT_W-1:0]     ext;
  logic [EXT_W-1:0]     shifted;

  always_comb begin
    hidden  = (exp_i != '0);
    e_eff   = hidden ? exp_i : {{(SRC_EXP_W-1){1'b0}}, 1'b1};
    tiny_o  = ({1'b0, e_eff} <= BDIFF);
    sh_full = BDIFF + 1'b1 - {1'b0, e_eff};
    if (!tiny_o)               sh = '0;
    else if (sh_full > SH_MAX) sh = SH_MAX;
    else                       sh = sh_full;
    ext      = {hidden, man_i, {SIG_W{1'b0}}};
    shifted  = ext >> sh;
    kept_o   = shifted[EXT_W-2 -: DST_MAN_W];
    guard_o  = shifted[GRD_POS];
    sticky_o = |shifted[GRD_POS-1:0];
    exp_o    = tiny_o ? '0 : ({1'b0, exp_i} - BDIFF);
  end

endmodule

// File: rtl/fp_narrow_round.sv
// Apply the rounding increment, handle the carry and resolve overflow for
// both the standard and the alternative narrow format.
module fp_narrow_round
  import fp_narrow_pkg::*;
#(
  parameter int SRC_EXP_W = 8,
  parameter int DST_EXP_W = 5,
  parameter int DST_MAN_W = 10
) (
  input  logic                 sign_i,
  input  logic [DST_MAN_W-1:0] kept_i,
  input  logic                 guard_i,
  input  logic                 sticky_i,
  input  logic                 tiny_i,
  input  logic [SRC_EXP_W:0]   exp_i,
  input  rmode_e               rmode_i,
  input  logic                 alt_fmt_i,
  input  logic                 uf_en_i,
  output logic [DST_EXP_W-1:0] exp_o,
  output logic [DST_MAN_W-1:0] man_o,
  output flags_t               flags_o
);
  localparam int IEEE_LIM_I = 2**DST_EXP_W - 1;
  localparam int ALT_LIM_I  = 2**DST_EXP_W;
  localparam logic [SRC_EXP_W:0] IEEE_LIM = IEEE_LIM_I[SRC_EXP_W:0];
  localparam logic [SRC_EXP_W:0] ALT_LIM  = ALT_LIM_I[SRC_EXP_W:0];

  logic                 dropped;
  logic                 inc;
  logic                 to_inf;
  logic [DST_MAN_W:0]   sum;
  logic [SRC_EXP_W:0]   exp_r;
  logic [DST_MAN_W-1:0] man_r;

  always_comb begin
    dropped = guard_i | sticky_i;
    unique case (rmode_i)
      RM_NEAREST: inc = guard_i & (sticky_i | kept_i[0]);
      RM_UP:      inc = ~sign_i & dropped;
      RM_DOWN:    inc = sign_i & dropped;
      default:    inc = 1'b0;
    endcase
    sum    = {1'b0, kept_i} + {{DST_MAN_W{1'b0}}, inc};
    exp_r  = exp_i + {{SRC_EXP_W{1'b0}}, sum[DST_MAN_W]};
    man_r  = sum[DST_MAN_W] ? '0 : sum[DST_MAN_W-1:0];
    to_inf = (rmode_i == RM_NEAREST) || (rmode_i == RM_UP && !sign_i) ||
             (rmode_i == RM_DOWN && sign_i);

    exp_o             = exp_r[DST_EXP_W-1:0];
    man_o             = man_r;
    flags_o.invalid   = 1'b0;
    flags_o.overflow  = 1'b0;
    flags_o.underflow = tiny_i & (dropped | uf_en_i);
    flags_o.inexact   = dropped;

    if (alt_fmt_i) begin
      if (exp_r >= ALT_LIM) begin
        exp_o           = '1;
        man_o           = '1;
        flags_o.invalid = 1'b1;
        flags_o.inexact = 1'b0;
      end
    end else if (exp_r >= IEEE_LIM) begin
      if (to_inf) begin
        exp_o = '1;
        man_o = '0;
      end else begin
        exp_o = {{(DST_EXP_W-1){1'b1}}, 1'b0};
        man_o = '1;
      end
      flags_o.overflow = 1'b1;
      flags_o.inexact  = 1'b1;
    end
  end

endmodule

// File: rtl/fp_narrow.sv
// Top level: special-value override, half merge and output register.
module fp_narrow
  import fp_narrow_pkg::*;
#(
  parameter int SRC_EXP_W = 8,
  parameter int SRC_MAN_W = 23,
  parameter int DST_EXP_W = 5,
  parameter int DST_MAN_W = 10
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [SRC_EXP_W+SRC_MAN_W:0]           op_i,
  input  logic [2*(1+DST_EXP_W+DST_MAN_W)-1:0]   dest_i,
  input  logic                                   sel_upper_i,
  input  logic [1:0]                             rmode_i,
  input  logic                                   alt_fmt_i,
  input  logic                                   dflt_nan_i,
  input  logic                                   uf_en_i,
  output logic [2*(1+DST_EXP_W+DST_MAN_W)-1:0]   word_o,
  output logic                                   flag_invalid_o,
  output logic                                   flag_overflow_o,
  output logic                                   flag_underflow_o,
  output logic                                   flag_inexact_o
);
  localparam int OP_W = 1 + SRC_EXP_W + SRC_MAN_W;
  localparam int HW   = 1 + DST_EXP_W + DST_MAN_W;
  localparam int WW   = 2 * HW;
  localparam logic [DST_MAN_W-1:0] QBIT = {1'b1, {(DST_MAN_W-1){1'b0}}};

  logic                 sign;
  logic [SRC_EXP_W-1:0] e_in;
  logic [SRC_MAN_W-1:0] m_in;
  logic                 is_nan, is_inf, is_zero;

  assign sign    = op_i[OP_W-1];
  assign e_in    = op_i[OP_W-2 -: SRC_EXP_W];
  assign m_in    = op_i[SRC_MAN_W-1:0];
  assign is_nan  = (&e_in) & (|m_in);
  assign is_inf  = (&e_in) & ~(|m_in);
  assign is_zero = ~(|e_in) & ~(|m_in);

  logic [DST_MAN_W-1:0] kept;
  logic                 guard, sticky, tiny;
  logic [SRC_EXP_W:0]   exp_rb;
  logic [DST_EXP_W-1:0] r_exp;
  logic [DST_MAN_W-1:0] r_man;
  flags_t               r_fl;

  fp_narrow_align #(
    .SRC_EXP_W(SRC_EXP_W), .SRC_MAN_W(SRC_MAN_W),
    .DST_EXP_W(DST_EXP_W), .DST_MAN_W(DST_MAN_W)
  ) align_i (
    .exp_i(e_in), .man_i(m_in), .kept_o(kept), .guard_o(guard),
    .sticky_o(sticky), .tiny_o(tiny), .exp_o(exp_rb)
  );

  fp_narrow_round #(
    .SRC_EXP_W(SRC_EXP_W), .DST_EXP_W(DST_EXP_W), .DST_MAN_W(DST_MAN_W)
  ) round_i (
    .sign_i(sign), .kept_i(kept), .guard_i(guard), .sticky_i(sticky),
    .tiny_i(tiny), .exp_i(exp_rb), .rmode_i(rmode_e'(rmode_i)),
    .alt_fmt_i(alt_fmt_i), .uf_en_i(uf_en_i),
    .exp_o(r_exp), .man_o(r_man), .flags_o(r_fl)
  );

  logic [HW-1:0] half_n;
  flags_t        fl_n;

  always_comb begin
    half_n = {sign, r_exp, r_man};
    fl_n   = r_fl;
    if (is_nan) begin
      fl_n         = '0;
      fl_n.invalid = ~m_in[SRC_MAN_W-1];
      if (alt_fmt_i) begin
        half_n       = {sign, {(HW-1){1'b0}}};
        fl_n.invalid = 1'b1;
      end else if (dflt_nan_i) begin
        half_n = {1'b0, {DST_EXP_W{1'b1}}, QBIT};
      end else begin
        half_n = {sign, {DST_EXP_W{1'b1}}, m_in[SRC_MAN_W-1 -: DST_MAN_W] | QBIT};
      end
    end else if (is_inf) begin
      fl_n = '0;
      if (alt_fmt_i) begin
        half_n       = {sign, {(HW-1){1'b1}}};
        fl_n.invalid = 1'b1;
      end else begin
        half_n = {sign, {DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};
      end
    end else if (is_zero) begin
      half_n = {sign, {(HW-1){1'b0}}};
      fl_n   = '0;
    end
  end

  logic [WW-1:0] word_n;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign word_n[h*HW +: HW] = (sel_upper_i == h[0]) ? half_n : dest_i[h*HW +: HW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o           <= '0;
      flag_invalid_o   <= 1'b0;
      flag_overflow_o  <= 1'b0;
      flag_underflow_o <= 1'b0;
      flag_inexact_o   <= 1'b0;
    end else begin
      word_o           <= word_n;
      flag_invalid_o   <= fl_n.invalid;
      flag_overflow_o  <= fl_n.overflow;
      flag_underflow_o <= fl_n.underflow;
      flag_inexact_o   <= fl_n.inexact;
    end
  end

  // R2
  keep_lower_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(sel_upper_i)) |-> word_o[HW-1:0] == $past(dest_i[HW-1:0]));

  // R2
  keep_upper_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(sel_upper_i)) |-> word_o[WW-1:HW] == $past(dest_i[WW-1:HW]));

  // R5
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
    flag_overflow_o |-> flag_inexact_o);

  // R6
  alt_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(alt_fmt_i)) |-> !flag_overflow_o);

  // R11
  zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_i[OP_W-2:0] == '0)) |->
      !(flag_invalid_o | flag_overflow_o | flag_underflow_o | flag_inexact_o));

  // R10
  uf_small_exp_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && flag_underflow_o) |->
      (($past(sel_upper_i) ? word_o[WW-2 -: DST_EXP_W] : word_o[HW-2 -: DST_EXP_W]) <= 1));

endmodule

// File: tb/fp_narrow_tb_top.sv
`timescale 1ns/1ps
module fp_narrow_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_i = '0, dest_i = '0;
  logic        sel_upper_i = 1'b0;
  logic [1:0]  rmode_i = 2'd0;
  logic        alt_fmt_i = 1'b0, dflt_nan_i = 1'b0, uf_en_i = 1'b0;
  logic [31:0] word_o;
  logic        flag_invalid_o, flag_overflow_o, flag_underflow_o, flag_inexact_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_narrow dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .dest_i(dest_i), .sel_upper_i(sel_upper_i),
    .rmode_i(rmode_i), .alt_fmt_i(alt_fmt_i), .dflt_nan_i(dflt_nan_i), .uf_en_i(uf_en_i),
    .word_o(word_o), .flag_invalid_o(flag_invalid_o), .flag_overflow_o(flag_overflow_o),
    .flag_underflow_o(flag_underflow_o), .flag_inexact_o(flag_inexact_o)
  );

  localparam logic [31:0] D = 32'hA5A5_5A5A;
  localparam int NV = 40;
  // {req, op, dest, sel, rmode, alt, dflt_nan, uf_en, half, flags{inv,ovf,unf,inx}}
  localparam logic [93:0] VEC [0:NV-1] = '{
    {4'd1,  32'h3F800000, D, 1'b1, 2'd0, 3'b000, 16'h3C00, 4'b0000}, // R1
    {4'd1,  32'hC0200000, D, 1'b0, 2'd0, 3'b000, 16'hC100, 4'b0000}, // R1
    {4'd3,  32'h3F801000, D, 1'b1, 2'd0, 3'b000, 16'h3C00, 4'b0001}, // R3
    {4'd3,  32'h3F801000, D, 1'b0, 2'd1, 3'b000, 16'h3C01, 4'b0001}, // R3
    {4'd3,  32'h3F801000, D, 1'b1, 2'd2, 3'b000, 16'h3C00, 4'b0001}, // R3
    {4'd3,  32'h3F803000, D, 1'b0, 2'd0, 3'b000, 16'h3C02, 4'b0001}, // R3
    {4'd3,  32'hBF800800, D, 1'b1, 2'd2, 3'b000, 16'hBC01, 4'b0001}, // R3
    {4'd3,  32'hBF800800, D, 1'b0, 2'd1, 3'b000, 16'hBC00, 4'b0001}, // R3
    {4'd3,  32'h3F803000, D, 1'b1, 2'd3, 3'b000, 16'h3C01, 4'b0001}, // R3
    {4'd5,  32'h47800000, D, 1'b0, 2'd0, 3'b000, 16'h7C00, 4'b0101}, // R5
    {4'd5,  32'h47800000, D, 1'b1, 2'd3, 3'b000, 16'h7BFF, 4'b0101}, // R5
    {4'd5,  32'hC7800000, D, 1'b0, 2'd1, 3'b000, 16'hFBFF, 4'b0101}, // R5
    {4'd5,  32'hC7800000, D, 1'b1, 2'd2, 3'b000, 16'hFC00, 4'b0101}, // R5
    {4'd4,  32'h477FF000, D, 1'b0, 2'd0, 3'b000, 16'h7C00, 4'b0101}, // R4
    {4'd1,  32'h477FE000, D, 1'b1, 2'd0, 3'b000, 16'h7BFF, 4'b0000}, // R1
    {4'd6,  32'h47800000, D, 1'b0, 2'd0, 3'b100, 16'h7C00, 4'b0000}, // R6
    {4'd6,  32'h48000001, D, 1'b1, 2'd0, 3'b100, 16'h7FFF, 4'b1000}, // R6
    {4'd6,  32'hC8000000, D, 1'b0, 2'd1, 3'b100, 16'hFFFF, 4'b1000}, // R6
    {4'd7,  32'h7F800000, D, 1'b1, 2'd0, 3'b000, 16'h7C00, 4'b0000}, // R7
    {4'd7,  32'h7F800000, D, 1'b0, 2'd0, 3'b100, 16'h7FFF, 4'b1000}, // R7
    {4'd7,  32'hFF800000, D, 1'b1, 2'd0, 3'b100, 16'hFFFF, 4'b1000}, // R7
    {4'd8,  32'h7FC12345, D, 1'b0, 2'd0, 3'b000, 16'h7E09, 4'b0000}, // R8
    {4'd8,  32'h7FC12345, D, 1'b1, 2'd0, 3'b010, 16'h7E00, 4'b0000}, // R8
    {4'd8,  32'hFF812345, D, 1'b0, 2'd0, 3'b000, 16'hFE09, 4'b1000}, // R8
    {4'd8,  32'hFF812345, D, 1'b1, 2'd0, 3'b010, 16'h7E00, 4'b1000}, // R8
    {4'd8,  32'h7FC12345, D, 1'b0, 2'd0, 3'b100, 16'h0000, 4'b1000}, // R8
    {4'd8,  32'hFF812345, D, 1'b1, 2'd0, 3'b110, 16'h8000, 4'b1000}, // R8
    {4'd11, 32'h80000000, D, 1'b0, 2'd0, 3'b000, 16'h8000, 4'b0000}, // R11
    {4'd11, 32'h00000000, D, 1'b1, 2'd1, 3'b001, 16'h0000, 4'b0000}, // R11
    {4'd9,  32'h33800000, D, 1'b0, 2'd0, 3'b000, 16'h0001, 4'b0000}, // R9
    {4'd10, 32'h33800000, D, 1'b1, 2'd0, 3'b001, 16'h0001, 4'b0010}, // R10
    {4'd9,  32'h33000000, D, 1'b0, 2'd0, 3'b000, 16'h0000, 4'b0011}, // R9
    {4'd9,  32'h33000000, D, 1'b1, 2'd1, 3'b000, 16'h0001, 4'b0011}, // R9
    {4'd9,  32'h33400000, D, 1'b0, 2'd0, 3'b000, 16'h0001, 4'b0011}, // R9
    {4'd4,  32'h387FF000, D, 1'b1, 2'd0, 3'b000, 16'h0400, 4'b0011}, // R4
    {4'd1,  32'h38800000, D, 1'b0, 2'd0, 3'b000, 16'h0400, 4'b0000}, // R1
    {4'd9,  32'h00000001, D, 1'b1, 2'd1, 3'b000, 16'h0001, 4'b0011}, // R9
    {4'd9,  32'h80000001, D, 1'b0, 2'd2, 3'b000, 16'h8001, 4'b0011}, // R9
    {4'd9,  32'h00000001, D, 1'b1, 2'd0, 3'b000, 16'h0000, 4'b0011}, // R9
    {4'd10, 32'h387FF000, D, 1'b0, 2'd3, 3'b000, 16'h03FF, 4'b0011}  // R10
  };

  task automatic check(input int req, input logic [31:0] exp_w, input logic [3:0] exp_f);
    logic [3:0] act_f;
    act_f = {flag_invalid_o, flag_overflow_o, flag_underflow_o, flag_inexact_o};
    checks++;
    if (word_o !== exp_w || act_f !== exp_f) begin
      failures++;
      $display("FAIL R%0d: word=%h flags=%b expected word=%h flags=%b",
               req, word_o, act_f, exp_w, exp_f);
    end
  endtask

  task automatic drive(input logic [31:0] op, input logic [31:0] dst, input logic sel,
                       input logic [1:0] rm, input logic [2:0] ctl);
    op_i = op; dest_i = dst; sel_upper_i = sel; rmode_i = rm;
    {alt_fmt_i, dflt_nan_i, uf_en_i} = ctl;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(12, 32'h0, 4'b0000);           // R12 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [93:0] v;
      logic [31:0] ew;
      v = VEC[i];
      drive(v[89:58], v[57:26], v[25], v[24:23], v[22:20]);
      ew = v[25] ? {v[19:4], v[41:26]} : {v[57:42], v[19:4]};
      @(negedge clk);
      check(int'(v[93:90]), ew, v[3:0]);
    end
    // R2 with another destination word, lower half written
    drive(32'h3F800000, 32'h1234_5678, 1'b0, 2'd0, 3'b000);
    @(negedge clk);
    check(2, 32'h1234_3C00, 4'b0000);
    // R12 output holds until the next rising edge
    drive(32'hC0200000, 32'h1234_5678, 1'b1, 2'd0, 3'b000);
    #1;
    check(12, 32'h1234_3C00, 4'b0000);
    @(negedge clk);
    check(12, 32'hC100_5678, 4'b0000);
    // R12 synchronous reset clears word and flags
    drive(32'h47800000, D, 1'b0, 2'd0, 3'b000);
    @(negedge clk);
    check(5, 32'hA5A5_7C00, 4'b0101);
    rst = 1'b1;
    @(negedge clk);
    check(12, 32'h0, 4'b0000);
    rst = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule